// File: doc/BRIEF.md
# Discrete-Time K-Winners-Take-All Selector

This block picks out the K largest of N signed fixed-point samples with a discrete-time feedback loop rather than a sorting network. A start pulse captures a new input vector and clears a single offset shared by every lane. Each output is its captured input plus that offset, and the outputs move together. On every sample strobe the block counts the signs of the N outputs and forms a small integer residual from the count, K and N. It scales the residual by a gain and folds it into the offset, which acts as an inverting integrator. Too many positive outputs pull the offset down. Too few push it up.

When the residual reaches zero the offset stops moving and a converged flag rises. If the inputs are distinct and the gap between the K-th and (K+1)-th largest is wider than the final step size, exactly the K largest inputs then give positive outputs. All the others sit at or below zero. The loop takes one step per strobe, so the strobe rate sets how fast it settles in real time.

The input vector is sampled only on the start pulse, and the outputs are continuous functions of internal state. There is no valid/ready handshake and no back-pressure. The caller holds the input vector steady on the start cycle and reads the outputs whenever it likes. The block never stalls its source.

Top module: `kwta_select`

## Requirements
- R1: Every lane value is a W-bit (default 12) two's-complement number with FRAC (default 6) fractional bits. Lane i of `in_vec` and `out_vec` occupies bits [W*i+W-1 : W*i].
- R2: When `start` is high at a clock edge, the inputs are captured, the offset is cleared to zero and `converged` drops. After that edge `out_vec` equals the captured inputs. `start` takes priority over `sample_en` in the same cycle.
- R3: Each output equals its captured input plus the shared offset, saturated to the W-bit range. The sum never wraps.
- R4: The sign of an output is +1 when it is above zero, 0 when it is exactly zero and -1 when it is below zero. The residual is R = 2K - N - (sum of the N signs).
- R5: At each clock edge where `sample_en` is high and `start` is low, the offset becomes sat(offset + delta). To form delta, ALPHA is multiplied by R taken as a FRAC-fraction value, giving a 2W-bit product with 2*FRAC fractional bits. That product is reduced to FRAC fractional bits rounding toward zero, then saturated to W bits.
- R6: At a clock edge where neither `start` nor `sample_en` is high, the offset, the outputs and `converged` all hold.
- R7: `converged` rises at the first sample edge whose residual is zero. It stays high, and the offset stays fixed, until the next start.
- R8: With distinct inputs and a gap of at least four steps of ALPHA*2 between the K-th and (K+1)-th largest, the loop converges. The outputs above zero are then exactly the lanes holding the K largest inputs.
- R9: The offset saturates at the W-bit limits. A loop that cannot settle pins the offset at a limit instead of wrapping.
- R10: After reset the captured inputs and the offset are zero, so every output reads zero, and `converged` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture `in_vec`, clear the offset and the converged flag |
| sample_en | input | 1 | Advance the loop by one integration step |
| in_vec | input | N*W | N packed signed input samples |
| out_vec | output | N*W | N packed signed outputs, each input plus the shared offset |
| converged | output | 1 | Residual has reached zero since the last start |

## Verification
The assertions check on every cycle four things. Each lane sum keeps its sign when both operands share it, so nothing wraps. A start loads the inputs straight to the outputs with a zero offset. Idle cycles change nothing. After convergence the flag and the offset stay frozen. Whether the loop finds the right winners takes the bench's scenarios to show, and so does its step-by-step offset trajectory against a model built from the equations. Those scenarios cover all-negative, all-positive and mixed inputs, an output that lands exactly on zero, and a vector that converges at once. They also cover a vector that drives the offset into saturation, and a start issued together with a sample strobe.

// File: rtl/kwta_pkg.sv
package kwta_pkg;
  typedef enum logic [1:0] {
    SGN_ZERO = 2'd0,
    SGN_POS  = 2'd1,
    SGN_NEG  = 2'd2
  } sgn_e;
endpackage

// File: rtl/kwta_lane.sv
module kwta_lane #(
  parameter int W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [W-1:0]  a,
  input  logic signed [W-1:0]  x,
  output logic signed [W-1:0]  b,
  output kwta_pkg::sgn_e       sg
);
  localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic signed [W:0] sum;

  always_comb begin
    sum = {a[W-1], a} + {x[W-1], x};
    if (sum[W] != sum[W-1]) b = sum[W] ? MINV : MAXV;
    else                    b = sum[W-1:0];
    if (b == '0)            sg = kwta_pkg::SGN_ZERO;
    else if (b[W-1])        sg = kwta_pkg::SGN_NEG;
    else                    sg = kwta_pkg::SGN_POS;
  end

  // R3: same-sign operands must never produce an opposite-sign result
  assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (a[W-1] == x[W-1]) |-> (b[W-1] == a[W-1]));
endmodule

// File: rtl/kwta_residual.sv
module kwta_residual #(
  parameter int N  = 6,
  parameter int K  = 3,
  parameter int RW = 6
) (
  input  kwta_pkg::sgn_e           sg [N],
  output logic signed [RW-1:0]     resid
);
  localparam logic signed [RW-1:0] BIAS = RW'(2 * K - N);
  localparam logic signed [RW-1:0] ONE  = RW'(1);

  always_comb begin
    resid = BIAS;
    for (int i = 0; i < N; i++) begin
      if (sg[i] == kwta_pkg::SGN_POS)      resid = resid - ONE;
      else if (sg[i] == kwta_pkg::SGN_NEG) resid = resid + ONE;
    end
  end
endmodule

// File: rtl/kwta_offset.sv
module kwta_offset #(
  parameter int                  W     = 12,
  parameter int                  FRAC  = 6,
  parameter int                  RW    = 6,
  parameter logic signed [W-1:0] ALPHA = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 sample_en,
  input  logic signed [RW-1:0] resid,
  output logic signed [W-1:0]  x,
  output logic                 conv
);
  localparam int PW = 2 * W;
  localparam logic signed [PW-1:0] RBIAS = PW'((1 << FRAC) - 1);
  localparam logic signed [PW-1:0] DHI   = PW'((1 << (W - 1)) - 1);
  localparam logic signed [PW-1:0] DLO   = PW'(-(1 << (W - 1)));
  localparam logic signed [W-1:0]  MAXV  = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0]  MINV  = {1'b1, {(W-1){1'b0}}};

  logic signed [PW-1:0] r_ext, a_ext, prod, red;
  logic signed [W-1:0]  delta, x_q, x_nxt;
  logic signed [W:0]    acc;
  logic                 conv_q;

  always_comb begin
    r_ext = PW'(resid) <<< FRAC;
    a_ext = PW'(ALPHA);
    prod  = a_ext * r_ext;
    red   = prod[PW-1] ? ((prod + RBIAS) >>> FRAC) : (prod >>> FRAC);
    if (red > DHI)      delta = MAXV;
    else if (red < DLO) delta = MINV;
    else                delta = red[W-1:0];
    acc = {x_q[W-1], x_q} + {delta[W-1], delta};
    if (acc[W] != acc[W-1]) x_nxt = acc[W] ? MINV : MAXV;
    else                    x_nxt = acc[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q    <= '0;
      conv_q <= 1'b0;
    end else if (start) begin
      x_q    <= '0;
      conv_q <= 1'b0;
    end else if (sample_en) begin
      x_q <= x_nxt;
      if (resid == '0) conv_q <= 1'b1;
    end
  end

  assign x    = x_q;
  assign conv = conv_q;

  // R2: a start clears the offset and the flag
  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (x_q == '0 && !conv_q));
  // R6: idle cycles change nothing
  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !sample_en) |=> ($stable(x_q) && $stable(conv_q)));
  // R7: flag is sticky until start
  assert_conv_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_q && !start) |=> conv_q);
  // R7: offset frozen once converged
  assert_conv_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_q && !start) |=> $stable(x_q));
endmodule

// File: rtl/kwta_select.sv
module kwta_select #(
  parameter int                  N     = 6,
  parameter int                  K     = 3,
  parameter int                  W     = 12,
  parameter int                  FRAC  = 6,
  parameter logic signed [W-1:0] ALPHA = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             sample_en,
  input  logic [N*W-1:0]   in_vec,
  output logic [N*W-1:0]   out_vec,
  output logic             converged
);
  localparam int RW = $clog2(2 * N) + 2;

  logic signed [W-1:0]  a_q [N];
  logic signed [W-1:0]  b   [N];
  kwta_pkg::sgn_e       sg  [N];
  logic signed [W-1:0]  x;
  logic signed [RW-1:0] resid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) a_q[i] <= '0;
    end else if (start) begin
      for (int i = 0; i < N; i++) a_q[i] <= in_vec[i*W +: W];
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_lane
    kwta_lane #(.W(W)) u_lane (
      .clk(clk), .rst_n(rst_n), .a(a_q[g]), .x(x), .b(b[g]), .sg(sg[g])
    );
    assign out_vec[g*W +: W] = b[g];
  end

  kwta_residual #(.N(N), .K(K), .RW(RW)) u_resid (
    .sg(sg), .resid(resid)
  );

  kwta_offset #(.W(W), .FRAC(FRAC), .RW(RW), .ALPHA(ALPHA)) u_offset (
    .clk(clk), .rst_n(rst_n), .start(start), .sample_en(sample_en),
    .resid(resid), .x(x), .conv(converged)
  );

  // R2: after a start edge the outputs equal the captured inputs
  assert_load_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (out_vec == $past(in_vec)));
endmodule

// File: tb/kwta_select_bench.sv
module kwta_select_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 6;
  localparam int K = 3;
  localparam int W = 12;
  localparam int ALPHA = 8;
  localparam int NV = 5;
  // six inputs (LSB units, 1/64) then the expected winner mask
  localparam int VEC [NV][7] = '{
    '{ 320, -192,   96,   45,  -13,  141, 6'b100101},
    '{-500, -100, -300,  -50, -700, -200, 6'b101010},
    '{1500, 1800,  900, 1200, 2000,  600, 6'b010011},
    '{  10, -900,  700,  -20,  400, -400, 6'b010101},
    '{   0,   64,  128,  -64, -128, -192, 6'b000111}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic sample_en = 1'b0;
  logic [N*W-1:0] in_vec = '0;
  logic [N*W-1:0] out_vec;
  logic converged;

  int checks = 0;
  int fails = 0;
  int ma [N];
  int mx = 0;
  int mconv = 0;

  kwta_select #(.N(N), .K(K), .W(W), .FRAC(6), .ALPHA(12'(ALPHA))) u_kwta_select (
    .clk(clk), .rst_n(rst_n), .start(start), .sample_en(sample_en),
    .in_vec(in_vec), .out_vec(out_vec), .converged(converged)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int sat(int v);
    if (v > 2047) return 2047;
    if (v < -2048) return -2048;
    return v;
  endfunction

  function automatic int lane(int i);
    logic signed [W-1:0] t;
    t = out_vec[i*W +: W];
    return int'(t);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_step();
    int s, r, b;
    s = 0;
    for (int i = 0; i < N; i++) begin
      b = sat(ma[i] + mx);
      s += (b > 0) ? 1 : ((b < 0) ? -1 : 0);
    end
    r = 2 * K - N - s;
    if (r == 0) mconv = 1;
    mx = sat(mx + sat((ALPHA * r * 64) / 64));
  endtask

  task automatic check_all(string req);
    for (int i = 0; i < N; i++) chk(req, lane(i), sat(ma[i] + mx));
    chk(req, int'(converged), mconv);
  endtask

  task automatic load(int v0, int v1, int v2, int v3, int v4, int v5, logic with_sample);
    int vals [N];
    vals = '{v0, v1, v2, v3, v4, v5};
    for (int i = 0; i < N; i++) begin
      in_vec[i*W +: W] = W'(vals[i]);
      ma[i] = vals[i];
    end
    start = 1'b1;
    sample_en = with_sample;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    sample_en = 1'b0;
    mx = 0;
    mconv = 0;
  endtask

  task automatic step();
    sample_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    sample_en = 1'b0;
    model_step();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int mask;
    for (int i = 0; i < N; i++) ma[i] = 0;
    repeat (3) @(negedge clk);
    // R10: reset state
    for (int i = 0; i < N; i++) chk("R10", lane(i), 0);
    chk("R10", int'(converged), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < N; i++) chk("R10", lane(i), 0);

    for (int v = 0; v < NV; v++) begin
      load(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5], 1'b0);
      // R1 R2: outputs equal captured inputs, flag low
      for (int i = 0; i < N; i++) chk("R1/R2", lane(i), VEC[v][i]);
      chk("R2", int'(converged), 0);
      if (v == 1) begin
        repeat (4) @(negedge clk);
        check_all("R6");
      end
      for (int n = 0; n < 400 && mconv == 0; n++) begin
        step();
        check_all("R5");
        if (v == 4 && n == 0) chk("R4", lane(0), 8);
      end
      chk("R7", int'(converged), 1);
      mask = 0;
      for (int i = 0; i < N; i++) if (lane(i) > 0) mask |= (1 << i);
      chk("R8", mask, VEC[v][6]);
      step();
      step();
      check_all("R7");
    end

    // R2: start wins over a simultaneous sample strobe
    load(10, -900, 700, -20, 400, -400, 1'b1);
    for (int i = 0; i < N; i++) chk("R2", lane(i), ma[i]);
    chk("R2", int'(converged), 0);

    // R9 R3: offset driven to its upper limit, saturated lanes do not wrap
    load(2047, 2047, -2048, -2048, -2048, -2048, 1'b0);
    for (int n = 0; n < 200; n++) begin
      step();
      check_all("R3");
    end
    chk("R3", lane(0), 2047);
    chk("R9", lane(2), -1);
    chk("R9", int'(converged), 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule